// File: doc/BRIEF.md
# D-PHY Receive Lane State Sequencer

This block watches one receive data lane and its clock lane after the analog front end has reduced them to digital levels. From the pair of single-ended low-power levels on the data lane it follows the handshake that takes the lane from the stop state into high-speed mode. It then searches the byte-aligned high-speed stream for the sync byte and forwards the payload that follows it as a framed byte stream. Each forwarded byte carries a valid strobe, a start-of-packet marker and an end-of-packet marker.

Entry is accepted only when the lines pass through stop, request and bridge in that order. Each intermediate state must also be held for a minimum number of clock cycles, which filters out line glitches. A break in that order, or a dwell that is too short, produces a single-cycle start error. A burst that never delivers the sync byte within a bounded number of bytes produces a sync error. The burst ends when the data lane returns to the stop state. The last byte is held back by one byte so that it can carry the end marker. A separate flag reports when both the data lane and the clock lane rest in the stop state.

Top module: `dphy_lane_seq`

## Requirements
- R1: After reset all outputs are low and the sequencer does not start until it has seen the stop state ({p,n} = 11). Before that stop state, non-stop line levels (00, 10) raise no error.
- R2: From the stop state, the ordered walk request (p=0, n=1), then bridge (00), then capture enable high while in bridge, arms the sequencer. The payload bytes that follow the sync byte are forwarded in order.
- R3: Any other walk raises `sot_err` for exactly one cycle. Examples are stop straight to bridge or to 10, request back to stop or to 10, and bridge to anything but bridge. After the error the sequencer ignores the lines until stop is seen again.
- R4: The request and bridge states must each last at least DWELL cycles. Leaving request after fewer cycles, or raising capture enable after fewer bridge cycles, raises `sot_err`.
- R5: While hunting, bytes before the sync value 0xB8 are discarded. The first byte after the sync carries `rx_sop`, and later bytes (including later 0xB8 values) are plain payload.
- R6: `sync_err` pulses for one cycle in two cases: after SYNC_TIMEOUT consecutive non-sync bytes, and when the lane returns to stop while still hunting. After a timeout, further bytes are ignored until stop. A sync value arriving as byte number SYNC_TIMEOUT is still accepted.
- R7: When the lane returns to stop during payload, the last captured byte is emitted with `rx_eop`. A one-byte payload carries both markers. A sync followed directly by stop emits nothing.
- R8: A byte strobe that arrives while capture enable is low is neither searched nor forwarded.
- R9: `lane_idle` is high one cycle after the data and clock lanes are both in the stop state, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte-domain clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lp_dp | input | 1 | Data lane positive low-power level |
| lp_dn | input | 1 | Data lane negative low-power level |
| lpclk_p | input | 1 | Clock lane positive low-power level |
| lpclk_n | input | 1 | Clock lane negative low-power level |
| hs_en | input | 1 | High-speed capture enable |
| hs_vld | input | 1 | Strobe: a deskewed byte is present on hs_byte |
| hs_byte | input | BYTE_W | Deskewed high-speed byte |
| rx_byte | output | BYTE_W | Forwarded payload byte |
| rx_vld | output | 1 | rx_byte is valid this cycle |
| rx_sop | output | 1 | First byte of a burst |
| rx_eop | output | 1 | Last byte of a burst |
| sot_err | output | 1 | One-cycle pulse: entry sequence broken |
| sync_err | output | 1 | One-cycle pulse: sync byte not found |
| lane_idle | output | 1 | Data and clock lanes both in stop state |

## Verification
The bench builds the sequencer with DWELL = 3 and SYNC_TIMEOUT = 6, in place of the larger defaults. With these values both dwell boundaries can be probed by holding a state for exactly DWELL or DWELL-1 cycles. The sync timeout can be hit with six junk bytes, and a sync value can be placed as the sixth byte to test the accept side of that boundary. Bytes are strobed every fourth cycle, which matches double-data-rate sampling of one byte.

// File: rtl/dphy_lane_pkg.sv
package dphy_lane_pkg;

  // Data lane line level as {p, n}
  typedef enum logic [1:0] {
    LN_BRIDGE = 2'b00,
    LN_REQ    = 2'b01,
    LN_ODD    = 2'b10,
    LN_STOP   = 2'b11
  } line_t;

  typedef enum logic [2:0] {
    ST_WAIT_STOP = 3'd0,
    ST_IDLE      = 3'd1,
    ST_REQ       = 3'd2,
    ST_BRIDGE    = 3'd3,
    ST_HUNT      = 3'd4,
    ST_PAYLOAD   = 3'd5
  } seq_state_t;

  localparam logic [7:0] SYNC_BYTE = 8'hB8;

endpackage

// File: rtl/lp_line_decode.sv
module lp_line_decode
  import dphy_lane_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  d_p,
  input  logic  d_n,
  input  logic  c_p,
  input  logic  c_n,
  output line_t d_line,
  output logic  lane_idle
);

  logic idle_n;

  assign d_line = line_t'({d_p, d_n});

  always_comb begin
    idle_n = d_p & d_n & c_p & c_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lane_idle <= 1'b0;
    else        lane_idle <= idle_n;
  end

  // R9: idle only follows a cycle with every line high
  p_idle_needs_stop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    lane_idle |-> $past(d_p && d_n && c_p && c_n));

endmodule

// File: rtl/lane_entry_fsm.sv
module lane_entry_fsm
  import dphy_lane_pkg::*;
#(
  parameter int unsigned BYTE_W       = 8,
  parameter int unsigned DWELL        = 4,
  parameter int unsigned SYNC_TIMEOUT = 32,
  parameter logic [BYTE_W-1:0] SYNC_PATTERN = BYTE_W'(SYNC_BYTE)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  line_t             line,
  input  logic              hs_en,
  input  logic              hs_vld,
  input  logic [BYTE_W-1:0] hs_byte,
  output logic              burst_start,
  output logic              capture,
  output logic              burst_close,
  output logic              sot_err,
  output logic              sync_err
);

  localparam int unsigned DWELL_W = $clog2(DWELL + 1);
  localparam int unsigned TMO_W   = $clog2(SYNC_TIMEOUT + 1);
  localparam logic [DWELL_W-1:0] DWELL_MIN = DWELL_W'(DWELL);
  localparam logic [TMO_W-1:0]   TMO_LAST  = TMO_W'(SYNC_TIMEOUT - 1);

  seq_state_t         st_q, st_n;
  logic [DWELL_W-1:0] dwell_q, dwell_n;
  logic [TMO_W-1:0]   tmo_q, tmo_n;
  logic               sot_n, sync_n;
  logic               byte_in;

  assign byte_in     = hs_en & hs_vld & (line != LN_STOP);
  assign capture     = (st_q == ST_PAYLOAD) & byte_in;
  assign burst_close = (st_q == ST_PAYLOAD) & (line == LN_STOP);
  assign burst_start = (st_q == ST_HUNT) & byte_in & (hs_byte == SYNC_PATTERN);

  always_comb begin
    st_n    = st_q;
    dwell_n = dwell_q;
    tmo_n   = tmo_q;
    sot_n   = 1'b0;
    sync_n  = 1'b0;
    unique case (st_q)
      ST_WAIT_STOP: begin
        if (line == LN_STOP) st_n = ST_IDLE;
      end
      ST_IDLE: begin
        if (line == LN_REQ) begin
          st_n    = ST_REQ;
          dwell_n = DWELL_W'(1);
        end else if (line != LN_STOP) begin
          sot_n = 1'b1;
          st_n  = ST_WAIT_STOP;
        end
      end
      ST_REQ: begin
        unique case (line)
          LN_REQ: begin
            if (dwell_q < DWELL_MIN) dwell_n = dwell_q + 1'b1;
          end
          LN_BRIDGE: begin
            if (dwell_q >= DWELL_MIN) begin
              st_n    = ST_BRIDGE;
              dwell_n = DWELL_W'(1);
            end else begin
              sot_n = 1'b1;
              st_n  = ST_WAIT_STOP;
            end
          end
          LN_STOP: begin
            sot_n = 1'b1;
            st_n  = ST_IDLE;
          end
          default: begin
            sot_n = 1'b1;
            st_n  = ST_WAIT_STOP;
          end
        endcase
      end
      ST_BRIDGE: begin
        if (line == LN_STOP) begin
          sot_n = 1'b1;
          st_n  = ST_IDLE;
        end else if (line != LN_BRIDGE) begin
          sot_n = 1'b1;
          st_n  = ST_WAIT_STOP;
        end else if (hs_en) begin
          if (dwell_q >= DWELL_MIN) begin
            st_n  = ST_HUNT;
            tmo_n = '0;
          end else begin
            sot_n = 1'b1;
            st_n  = ST_WAIT_STOP;
          end
        end else if (dwell_q < DWELL_MIN) begin
          dwell_n = dwell_q + 1'b1;
        end
      end
      ST_HUNT: begin
        if (line == LN_STOP) begin
          sync_n = 1'b1;
          st_n   = ST_IDLE;
        end else if (byte_in) begin
          if (hs_byte == SYNC_PATTERN) begin
            st_n = ST_PAYLOAD;
          end else if (tmo_q == TMO_LAST) begin
            sync_n = 1'b1;
            st_n   = ST_WAIT_STOP;
          end else begin
            tmo_n = tmo_q + 1'b1;
          end
        end
      end
      ST_PAYLOAD: begin
        if (line == LN_STOP) st_n = ST_IDLE;
      end
      default: st_n = ST_WAIT_STOP;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_WAIT_STOP;
      dwell_q  <= '0;
      tmo_q    <= '0;
      sot_err  <= 1'b0;
      sync_err <= 1'b0;
    end else begin
      st_q     <= st_n;
      dwell_q  <= dwell_n;
      tmo_q    <= tmo_n;
      sot_err  <= sot_n;
      sync_err <= sync_n;
    end
  end

  // R2: hunting is reached only through the bridge state
  p_hunt_from_bridge_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_HUNT) |-> ($past(st_q) == ST_BRIDGE || $past(st_q) == ST_HUNT));

  // R4: the request state was held long enough before bridge was accepted
  p_req_dwell_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_BRIDGE && $past(st_q) == ST_REQ) |-> ($past(dwell_q) >= DWELL_MIN));

  // R3: an entry error always leaves the sequencer waiting at rest
  p_sot_rests_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sot_err |-> (st_q == ST_IDLE || st_q == ST_WAIT_STOP));

  // R6: a sync failure never leaves the sequencer inside a burst
  p_sync_rests_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sync_err |-> (st_q == ST_IDLE || st_q == ST_WAIT_STOP));

endmodule

// File: rtl/lane_byte_framer.sv
module lane_byte_framer #(
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              burst_start,
  input  logic              capture,
  input  logic              burst_close,
  input  logic [BYTE_W-1:0] in_byte,
  output logic [BYTE_W-1:0] out_byte,
  output logic              out_vld,
  output logic              out_sop,
  output logic              out_eop
);

  logic [BYTE_W-1:0] held_q, held_n;
  logic              held_v_q, held_v_n;
  logic              held_first_q, held_first_n;
  logic              first_pend_q, first_pend_n;
  logic [BYTE_W-1:0] ob_n;
  logic              ov_n, os_n, oe_n;

  always_comb begin
    held_n       = held_q;
    held_v_n     = held_v_q;
    held_first_n = held_first_q;
    first_pend_n = first_pend_q;
    ob_n         = out_byte;
    ov_n         = 1'b0;
    os_n         = 1'b0;
    oe_n         = 1'b0;
    if (burst_start) begin
      held_v_n     = 1'b0;
      first_pend_n = 1'b1;
    end else if (capture) begin
      if (held_v_q) begin
        ob_n = held_q;
        ov_n = 1'b1;
        os_n = held_first_q;
      end
      held_n       = in_byte;
      held_first_n = first_pend_q;
      first_pend_n = 1'b0;
      held_v_n     = 1'b1;
    end else if (burst_close) begin
      if (held_v_q) begin
        ob_n = held_q;
        ov_n = 1'b1;
        os_n = held_first_q;
        oe_n = 1'b1;
      end
      held_v_n     = 1'b0;
      first_pend_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_q       <= '0;
      held_v_q     <= 1'b0;
      held_first_q <= 1'b0;
      first_pend_q <= 1'b0;
      out_byte     <= '0;
      out_vld      <= 1'b0;
      out_sop      <= 1'b0;
      out_eop      <= 1'b0;
    end else begin
      held_q       <= held_n;
      held_v_q     <= held_v_n;
      held_first_q <= held_first_n;
      first_pend_q <= first_pend_n;
      out_byte     <= ob_n;
      out_vld      <= ov_n;
      out_sop      <= os_n;
      out_eop      <= oe_n;
    end
  end

  // R7: closing a burst drains the held byte
  p_close_drains_r7: assert property (@(posedge clk) disable iff (!rst_n)
    burst_close |=> !held_v_q);

  // R7: an end marker only travels with a valid byte
  p_eop_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_eop |-> out_vld);

  // R5: a fresh sync empties the holding stage before payload arrives
  p_start_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    burst_start |=> (!held_v_q && first_pend_q));

endmodule

// File: rtl/dphy_lane_seq.sv
module dphy_lane_seq
  import dphy_lane_pkg::*;
#(
  parameter int unsigned BYTE_W       = 8,
  parameter int unsigned DWELL        = 4,
  parameter int unsigned SYNC_TIMEOUT = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lp_dp,
  input  logic              lp_dn,
  input  logic              lpclk_p,
  input  logic              lpclk_n,
  input  logic              hs_en,
  input  logic              hs_vld,
  input  logic [BYTE_W-1:0] hs_byte,
  output logic [BYTE_W-1:0] rx_byte,
  output logic              rx_vld,
  output logic              rx_sop,
  output logic              rx_eop,
  output logic              sot_err,
  output logic              sync_err,
  output logic              lane_idle
);

  line_t d_line;
  logic  burst_start, capture, burst_close;

  lp_line_decode u_decode (
    .clk       (clk),
    .rst_n     (rst_n),
    .d_p       (lp_dp),
    .d_n       (lp_dn),
    .c_p       (lpclk_p),
    .c_n       (lpclk_n),
    .d_line    (d_line),
    .lane_idle (lane_idle)
  );

  lane_entry_fsm #(
    .BYTE_W       (BYTE_W),
    .DWELL        (DWELL),
    .SYNC_TIMEOUT (SYNC_TIMEOUT)
  ) u_entry (
    .clk         (clk),
    .rst_n       (rst_n),
    .line        (d_line),
    .hs_en       (hs_en),
    .hs_vld      (hs_vld),
    .hs_byte     (hs_byte),
    .burst_start (burst_start),
    .capture     (capture),
    .burst_close (burst_close),
    .sot_err     (sot_err),
    .sync_err    (sync_err)
  );

  lane_byte_framer #(
    .BYTE_W (BYTE_W)
  ) u_framer (
    .clk         (clk),
    .rst_n       (rst_n),
    .burst_start (burst_start),
    .capture     (capture),
    .burst_close (burst_close),
    .in_byte     (hs_byte),
    .out_byte    (rx_byte),
    .out_vld     (rx_vld),
    .out_sop     (rx_sop),
    .out_eop     (rx_eop)
  );

  // R3/R6: the two error pulses never coincide
  p_err_exclusive_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sot_err, sync_err}));

endmodule

// File: tb/dphy_lane_seq_bench.sv
module dphy_lane_seq_bench;

  localparam int DWELL = 3;
  localparam int TMO   = 6;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       lp_dp, lp_dn, lpclk_p, lpclk_n;
  logic       hs_en, hs_vld;
  logic [7:0] hs_byte;
  logic [7:0] rx_byte;
  logic       rx_vld, rx_sop, rx_eop, sot_err, sync_err, lane_idle;

  int checks = 0;
  int errors = 0;
  int sot_cnt = 0;
  int sync_cnt = 0;
  logic [9:0] expq[$];

  always #5 clk = ~clk;

  dphy_lane_seq #(.BYTE_W(8), .DWELL(DWELL), .SYNC_TIMEOUT(TMO)) u_dphy_lane_seq (
    .clk(clk), .rst_n(rst_n), .lp_dp(lp_dp), .lp_dn(lp_dn),
    .lpclk_p(lpclk_p), .lpclk_n(lpclk_n), .hs_en(hs_en), .hs_vld(hs_vld),
    .hs_byte(hs_byte), .rx_byte(rx_byte), .rx_vld(rx_vld), .rx_sop(rx_sop),
    .rx_eop(rx_eop), .sot_err(sot_err), .sync_err(sync_err), .lane_idle(lane_idle)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Monitor: scoreboard for the byte stream (R2, R5, R7) and error pulse counts
  always @(negedge clk) begin
    if (rst_n) begin
      if (sot_err)  sot_cnt++;
      if (sync_err) sync_cnt++;
      if (rx_vld) begin
        if (expq.size() == 0) begin
          check(1'b0, "R2 unexpected byte", {rx_byte, rx_sop, rx_eop}, 0);
        end else begin
          logic [9:0] e;
          e = expq.pop_front();
          check({rx_byte, rx_sop, rx_eop} == e, "R2/R5/R7 byte+sop+eop",
                {rx_byte, rx_sop, rx_eop}, e);
        end
      end
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_lp(input bit p, input bit n);
    lp_dp = p;
    lp_dn = n;
  endtask

  task automatic send_byte(input logic [7:0] b);
    hs_byte = b;
    hs_vld  = 1'b1;
    step(1);
    hs_vld  = 1'b0;
    step(3);
  endtask

  task automatic enter(input int nreq, input int nbr);
    set_lp(1, 1); lpclk_p = 1'b0; lpclk_n = 1'b0; step(2);
    set_lp(0, 1); step(nreq);
    set_lp(0, 0); step(nbr);
    hs_en = 1'b1; step(1);
  endtask

  task automatic stop_lane();
    set_lp(1, 1);
    hs_en = 1'b0;
    step(3);
  endtask

  task automatic burst(input int npre, input int npay, input int seed, input bit gap);
    enter(DWELL, DWELL);
    for (int i = 0; i < npre; i++) send_byte(8'h10 + 8'(i));
    send_byte(8'hB8);
    for (int i = 0; i < npay; i++) begin
      logic [7:0] b;
      b = 8'(seed * 37 + i * 13);
      if (i == 1) b = 8'hB8; // later sync value is plain payload (R5)
      expq.push_back({b, i == 0, i == npay - 1});
      send_byte(b);
      if (gap && i == 0) begin
        // R8: strobe with capture enable low must vanish
        hs_en = 1'b0;
        send_byte(8'h5A);
        hs_en = 1'b1;
      end
    end
    stop_lane();
    check(expq.size() == 0, "R7 all bytes drained", expq.size(), 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int s0, y0;
    rst_n = 1'b0;
    set_lp(0, 0); lpclk_p = 1'b0; lpclk_n = 1'b0;
    hs_en = 1'b0; hs_vld = 1'b0; hs_byte = '0;
    step(3);
    rst_n = 1'b1;
    step(1);
    // R1: reset values
    check({rx_vld, rx_sop, rx_eop, sot_err, sync_err, lane_idle} == 6'b0, "R1 reset outputs",
          {rx_vld, rx_sop, rx_eop, sot_err, sync_err, lane_idle}, 0);
    // R1: before first stop, odd levels give no error
    set_lp(0, 0); step(3); set_lp(1, 0); step(3);
    check(sot_cnt == 0, "R1 silent before stop", sot_cnt, 0);

    // R9: data stop with clock lane busy is not idle; both stop is idle
    set_lp(1, 1); lpclk_p = 1'b0; lpclk_n = 1'b0; step(2);
    check(lane_idle == 1'b0, "R9 clock lane busy", lane_idle, 0);
    lpclk_p = 1'b1; lpclk_n = 1'b1; step(1);
    check(lane_idle == 1'b1, "R9 all lanes stop", lane_idle, 1);
    set_lp(0, 1); step(1);
    check(lane_idle == 1'b0, "R9 data lane leaves stop", lane_idle, 0);
    set_lp(1, 1); step(2);

    // R2/R5: regular burst, TMO-1 junk bytes before sync is still accepted (R6 boundary)
    s0 = sot_cnt; y0 = sync_cnt;
    burst(TMO - 1, 5, 3, 1'b0);
    check(sot_cnt == s0 && sync_cnt == y0, "R6 sync on last allowed byte", sync_cnt - y0, 0);

    // R8: burst with a disabled strobe in the middle
    burst(1, 4, 7, 1'b1);

    // R7: one-byte burst carries both markers
    burst(0, 1, 11, 1'b0);

    // R7: sync then stop emits nothing
    enter(DWELL, DWELL);
    send_byte(8'hB8);
    stop_lane();
    check(expq.size() == 0 && sync_cnt == y0, "R7 empty burst silent", sync_cnt - y0, 0);

    // R3: stop straight to bridge; single pulse then silent until stop
    s0 = sot_cnt;
    set_lp(1, 1); step(2);
    set_lp(0, 0); step(1);
    check(sot_err == 1'b1, "R3 stop->bridge error", sot_err, 1);
    step(1);
    check(sot_err == 1'b0, "R3 pulse one cycle", sot_err, 0);
    step(4);
    check(sot_cnt == s0 + 1, "R3 waits for stop", sot_cnt - s0, 1);

    // R3: request back to stop
    s0 = sot_cnt;
    set_lp(1, 1); step(2);
    set_lp(0, 1); step(DWELL);
    set_lp(1, 1); step(3);
    check(sot_cnt == s0 + 1, "R3 request->stop error", sot_cnt - s0, 1);

    // R3: request to 10
    s0 = sot_cnt;
    set_lp(0, 1); step(DWELL);
    set_lp(1, 0); step(3);
    check(sot_cnt == s0 + 1, "R3 request->10 error", sot_cnt - s0, 1);

    // R4: request too short
    s0 = sot_cnt;
    set_lp(1, 1); step(2);
    set_lp(0, 1); step(DWELL - 1);
    set_lp(0, 0); step(3);
    check(sot_cnt == s0 + 1, "R4 short request", sot_cnt - s0, 1);

    // R4: bridge too short before capture enable
    s0 = sot_cnt;
    enter(DWELL, DWELL - 1);
    step(2);
    check(sot_cnt == s0 + 1, "R4 short bridge", sot_cnt - s0, 1);
    send_byte(8'hB8); send_byte(8'h42);
    stop_lane();
    check(expq.size() == 0, "R4 no data after bad entry", expq.size(), 0);

    // R6: timeout, later sync and data ignored
    y0 = sync_cnt;
    enter(DWELL, DWELL);
    for (int i = 0; i < TMO; i++) send_byte(8'h20 + 8'(i));
    check(sync_cnt == y0 + 1, "R6 timeout error", sync_cnt - y0, 1);
    send_byte(8'hB8); send_byte(8'h33); send_byte(8'h44);
    stop_lane();
    check(sync_cnt == y0 + 1, "R6 ignored until stop", sync_cnt - y0, 1);

    // R6: stop while hunting
    y0 = sync_cnt;
    enter(DWELL, DWELL);
    send_byte(8'h01);
    stop_lane();
    check(sync_cnt == y0 + 1, "R6 stop while hunting", sync_cnt - y0, 1);

    // Normal operation resumes after errors (R2)
    burst(2, 3, 19, 1'b0);
    step(4);
    check(expq.size() == 0, "R2 final drain", expq.size(), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule